// File: doc/BRIEF.md
# Infrared Run-Length Receive Sampler

This block watches a demodulated infrared receive bit that is already synchronous to the block clock. At a programmable sample interval, it measures how long the input stays at one level. Each time the level changes, it emits one byte that describes the run that just ended. Bit 7 of the byte tells whether the run was a space or a pulse, and the lower seven bits give the run length counted in sample periods. A run that keeps its level for too long is cut into saturated pieces, so no run is ever lost.

The bytes go into an eight-entry buffer built as two halves of four entries. The host reads one half while the hardware fills the other. When the fourth byte of a half is written, a half-select flag records which half is complete and a pending flag is raised. This lets the host read that half over the plain read port. The pending flag drives the interrupt line through an enable, and the host clears it by writing a one. Configuration arrives as plain input pins: enable, input polarity, sample period, interrupt enable and overflow-interrupt enable.

Top module: `irrx_sampler`

## Requirements
- R1: A sample tick occurs once every `cfg_period` microseconds, where one microsecond is `CLK_PER_US` clock cycles. A run held for k ticks produces a byte whose length field (bits 6:0) equals k.
- R2: In a sample byte, bit 7 = 1 marks a space (effective level 0) and bit 7 = 0 marks a pulse (effective level 1). Bits 6:0 hold the run length.
- R3: A `cfg_period` value of 0 selects the default interval of `DEF_PERIOD_US` microseconds (50 by default).
- R4: When `cfg_invert` = 1, the effective level is the inverse of `rx_in`, so a high input is recorded as a space.
- R5: A run that reaches 127 ticks emits a saturated byte with length 127 (0x7F for a pulse, 0xFF for a space). Counting then restarts at zero for a new run of the same level, so a level change 3 ticks later emits length 3.
- R6: Bytes are written in emission order to buffer addresses 0, 1, …, 7 and then wrap back to 0. `rd_data` shows the byte at `rd_addr` combinationally.
- R7: When the fourth byte of a half is written, `half_sel` takes that half's index: 0 for addresses 0–3, 1 for addresses 4–7.
- R8: `rx_pend` is set when a half completes. A saturated byte also sets it, but only while `cfg_ovf_irq_en` = 1.
- R9: A one-cycle pulse on `pend_clr` clears `rx_pend`. If a new set happens in the same cycle, the set takes priority.
- R10: `irq` equals `rx_pend` AND `cfg_irq_en`.
- R11: While `cfg_en` = 0, no ticks occur and no bytes are written, and any partial run is discarded. The first tick after enabling only starts a new run and emits nothing.
- R12: After reset, `rx_pend`, `irq` and `half_sel` are 0 and every buffer byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Demodulated receive bit, synchronous to clk |
| cfg_en | input | 1 | Receive enable; gates all sampling |
| cfg_invert | input | 1 | Invert input polarity |
| cfg_period | input | PER_W | Sample interval in microseconds; 0 selects the default |
| cfg_irq_en | input | 1 | Pass the pending flag to `irq` |
| cfg_ovf_irq_en | input | 1 | Let saturated runs set the pending flag |
| pend_clr | input | 1 | Write-one pulse that clears the pending flag |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| half_sel | output | 1 | Index of the half most recently completed |
| rx_pend | output | 1 | Receive-pending flag |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- the interrupt never rises without both the pending flag and its enable;
- an emitted byte never carries a zero length;
- every saturation event carries length 127;
- the half flag and the pending flag only change because a byte was written;
- nothing is emitted while the block is disabled;
- a clear with no concurrent set takes effect.

Only the directed scenarios can show the actual byte values for a given stream of levels: the space/pulse encoding, polarity inversion, the default interval, address ordering and wrap, and the fresh start after re-enabling.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
   // Width of the run-length field inside one sample byte
   localparam int RUN_W = 7;

   // One sample: space flag in the top bit, run length below it
   typedef struct packed {
      logic             space;
      logic [RUN_W-1:0] len;
   } irrx_smp_t;

   localparam int SMP_W = $bits(irrx_smp_t);
endpackage

// File: rtl/irrx_tick.sv
module irrx_tick #(
   parameter int CLK_PER_US    = 50,
   parameter int PER_W         = 8,
   parameter int DEF_PERIOD_US = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PER_W-1:0] period,
   output logic             tick
);
   localparam logic [PER_W-1:0] DEF_P = PER_W'(DEF_PERIOD_US);

   logic             us_tick;
   logic [PER_W-1:0] eff;
   logic [PER_W-1:0] per_cnt;

   // Microsecond prescaler: removed entirely when the clock already runs at 1 MHz
   generate
      if (CLK_PER_US == 1) begin : g_nodiv
         assign us_tick = en;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_PER_US);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_US - 1);
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !en) div_cnt <= '0;
            else if (div_cnt == LAST) div_cnt <= '0;
            else div_cnt <= div_cnt + 1'b1;
         end
         assign us_tick = en && (div_cnt == LAST);
      end
   endgenerate

   assign eff = (period == '0) ? DEF_P : period;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) per_cnt <= '0;
      else if (us_tick) begin
         if (per_cnt >= eff - 1'b1) per_cnt <= '0;
         else per_cnt <= per_cnt + 1'b1;
      end
   end

   assign tick = us_tick && (per_cnt >= eff - 1'b1);
endmodule

// File: rtl/irrx_run.sv
module irrx_run
   import irrx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      tick,
   input  logic      lvl,
   output logic      smp_vld,
   output irrx_smp_t smp,
   output logic      ovf
);
   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

   logic             active;
   logic             cur_lvl;
   logic [RUN_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur_lvl <= 1'b0;
         cnt     <= '0;
         smp_vld <= 1'b0;
         smp     <= '0;
         ovf     <= 1'b0;
      end else begin
         smp_vld <= 1'b0;
         ovf     <= 1'b0;
         if (!en) begin
            active <= 1'b0;
         end else if (tick) begin
            if (!active) begin
               // first tick after enabling only opens a run
               active  <= 1'b1;
               cur_lvl <= lvl;
               cnt     <= RUN_W'(1);
            end else if (lvl != cur_lvl) begin
               if (cnt != '0) begin
                  smp_vld   <= 1'b1;
                  smp.space <= ~cur_lvl;
                  smp.len   <= cnt;
               end
               cur_lvl <= lvl;
               cnt     <= RUN_W'(1);
            end else if (cnt == RUN_MAX - 1'b1) begin
               // saturated piece; same level continues from zero
               smp_vld   <= 1'b1;
               smp.space <= ~cur_lvl;
               smp.len   <= RUN_MAX;
               ovf       <= 1'b1;
               cnt       <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/irrx_buf.sv
module irrx_buf #(
   parameter int HALF_DEPTH = 4,
   parameter int SMP_W      = 8,
   localparam int HW        = $clog2(HALF_DEPTH),
   localparam int AW        = HW + 1,
   localparam int DEPTH     = 2 * HALF_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_byte,
   input  logic             ovf,
   input  logic             ovf_en,
   input  logic             pend_clr,
   input  logic [AW-1:0]    rd_addr,
   output logic [SMP_W-1:0] rd_data,
   output logic             half_sel,
   output logic             pend
);
   logic [AW-1:0]    wptr;
   logic             half_done;
   logic             pend_set;
   logic [SMP_W-1:0] lane_rd [DEPTH];

   // one storage lane per buffer entry
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_lane
         logic [SMP_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (smp_vld && (wptr == AW'(i))) q <= smp_byte;
         end
         assign lane_rd[i] = q;
      end
   endgenerate

   assign rd_data   = lane_rd[rd_addr];
   assign half_done = smp_vld && (wptr[HW-1:0] == {HW{1'b1}});
   assign pend_set  = half_done || (ovf && ovf_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr     <= '0;
         half_sel <= 1'b0;
         pend     <= 1'b0;
      end else begin
         if (smp_vld) wptr <= wptr + 1'b1;
         if (half_done) half_sel <= wptr[AW-1];
         if (pend_set) pend <= 1'b1;
         else if (pend_clr) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/irrx_sampler.sv
module irrx_sampler
   import irrx_pkg::*;
#(
   parameter int CLK_PER_US    = 50,
   parameter int PER_W         = 8,
   parameter int DEF_PERIOD_US = 50,
   parameter int HALF_DEPTH    = 4,
   localparam int AW           = $clog2(HALF_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_in,
   input  logic             cfg_en,
   input  logic             cfg_invert,
   input  logic [PER_W-1:0] cfg_period,
   input  logic             cfg_irq_en,
   input  logic             cfg_ovf_irq_en,
   input  logic             pend_clr,
   input  logic [AW-1:0]    rd_addr,
   output logic [SMP_W-1:0] rd_data,
   output logic             half_sel,
   output logic             rx_pend,
   output logic             irq
);
   // elaboration-time parameter checks
   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("CLK_PER_US must be at least 1");
      end
      if (HALF_DEPTH < 2 || (HALF_DEPTH & (HALF_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("HALF_DEPTH must be a power of two, at least 2");
      end
      if (DEF_PERIOD_US < 1 || DEF_PERIOD_US >= (1 << PER_W)) begin : g_bad_def
         $error("DEF_PERIOD_US must fit in PER_W bits and be non-zero");
      end
   endgenerate

   logic             tick;
   logic             lvl;
   logic             smp_vld;
   irrx_smp_t        smp;
   logic [SMP_W-1:0] smp_byte;
   logic             ovf_evt;

   assign lvl      = rx_in ^ cfg_invert;
   assign smp_byte = smp;

   irrx_tick #(
      .CLK_PER_US   (CLK_PER_US),
      .PER_W        (PER_W),
      .DEF_PERIOD_US(DEF_PERIOD_US)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_en),
      .period(cfg_period),
      .tick  (tick)
   );

   irrx_run u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_en),
      .tick   (tick),
      .lvl    (lvl),
      .smp_vld(smp_vld),
      .smp    (smp),
      .ovf    (ovf_evt)
   );

   irrx_buf #(
      .HALF_DEPTH(HALF_DEPTH),
      .SMP_W     (SMP_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .smp_byte(smp_byte),
      .ovf     (ovf_evt),
      .ovf_en  (cfg_ovf_irq_en),
      .pend_clr(pend_clr),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .half_sel(half_sel),
      .pend    (rx_pend)
   );

   assign irq = rx_pend & cfg_irq_en;
endmodule

// File: rtl/irrx_sampler_chk.sv
module irrx_sampler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_en,
   input logic       cfg_irq_en,
   input logic       irq,
   input logic       rx_pend,
   input logic       half_sel,
   input logic       pend_clr,
   input logic       smp_vld,
   input logic [6:0] smp_len,
   input logic       ovf
);
   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cfg_irq_en && rx_pend));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !smp_vld);

   // R1
   nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> (smp_len != 7'd0));

   // R5
   sat_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (smp_vld && smp_len == 7'h7F));

   // R7
   half_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(half_sel) |-> $past(smp_vld));

   // R8
   pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_pend) |-> $past(smp_vld));

   // R9
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pend && pend_clr && !smp_vld) |=> !rx_pend);
endmodule

bind irrx_sampler irrx_sampler_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .cfg_irq_en(cfg_irq_en),
   .irq       (irq),
   .rx_pend   (rx_pend),
   .half_sel  (half_sel),
   .pend_clr  (pend_clr),
   .smp_vld   (smp_vld),
   .smp_len   (smp_byte[6:0]),
   .ovf       (ovf_evt)
);

// File: tb/sim_irrx_sampler.sv
module sim_irrx_sampler;
   localparam int CPU = 2;   // clocks per microsecond in this bench
   localparam int AW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_in = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_invert = 1'b0;
   logic [7:0]    cfg_period = 8'd3;
   logic          cfg_irq_en = 1'b0;
   logic          cfg_ovf_irq_en = 1'b0;
   logic          pend_clr = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          half_sel;
   logic          rx_pend;
   logic          irq;

   int n_tests = 0;
   int n_fail  = 0;
   int tclk    = 6;   // clocks per sample tick

   always #10 clk = ~clk;

   irrx_sampler #(.CLK_PER_US(CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_en(cfg_en),
      .cfg_invert(cfg_invert), .cfg_period(cfg_period),
      .cfg_irq_en(cfg_irq_en), .cfg_ovf_irq_en(cfg_ovf_irq_en),
      .pend_clr(pend_clr), .rd_addr(rd_addr), .rd_data(rd_data),
      .half_sel(half_sel), .rx_pend(rx_pend), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_byte(input string tag, input int a, input logic [7:0] exp);
      rd_addr = AW'(a);
      #1;
      chk(tag, {24'd0, rd_data}, {24'd0, exp});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_en = 1'b0; cfg_invert = 1'b0; cfg_period = 8'd3;
      cfg_irq_en = 1'b0; cfg_ovf_irq_en = 1'b0; pend_clr = 1'b0; rx_in = 1'b0;
      tclk = 3 * CPU;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic hold(input logic l, input int ticks);
      rx_in = l;
      repeat (ticks * tclk) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R12 pend", {31'd0, rx_pend}, 0);
      chk("R12 irq", {31'd0, irq}, 0);
      chk("R12 half", {31'd0, half_sel}, 0);
      for (int a = 0; a < 8; a++) chk_byte("R12 byte", a, 8'h00);
   endtask

   task automatic t_main();
      do_reset();
      cfg_irq_en = 1'b1;
      cfg_en = 1'b1;
      hold(1, 5); hold(0, 3); hold(1, 2); hold(0, 7);
      hold(1, 4);
      chk_byte("R1 R2 pulse5", 0, 8'h05);
      chk_byte("R2 space3", 1, 8'h83);
      chk_byte("R6 pulse2", 2, 8'h02);
      chk_byte("R6 space7", 3, 8'h87);
      chk("R8 pend half0", {31'd0, rx_pend}, 1);
      chk("R7 half0", {31'd0, half_sel}, 0);
      chk("R10 irq on", {31'd0, irq}, 1);
      cfg_irq_en = 1'b0; #1;
      chk("R10 irq masked", {31'd0, irq}, 0);
      cfg_irq_en = 1'b1;
      pend_clr = 1'b1; @(negedge clk); pend_clr = 1'b0;
      chk("R9 cleared", {31'd0, rx_pend}, 0);
      repeat (tclk - 1) @(negedge clk);
      hold(0, 6); hold(1, 1); hold(0, 2); hold(1, 2);
      chk_byte("R6 addr4", 4, 8'h05);
      chk_byte("R6 addr5", 5, 8'h86);
      chk_byte("R6 addr6", 6, 8'h01);
      chk_byte("R6 addr7", 7, 8'h82);
      chk("R7 half1", {31'd0, half_sel}, 1);
      chk("R8 pend half1", {31'd0, rx_pend}, 1);
      hold(0, 2);
      chk_byte("R6 wrap", 0, 8'h02);
   endtask

   task automatic t_invert();
      do_reset();
      cfg_invert = 1'b1;
      cfg_en = 1'b1;
      hold(1, 4); hold(0, 3); hold(1, 2);
      chk_byte("R4 high is space", 0, 8'h84);
      chk_byte("R4 low is pulse", 1, 8'h03);
   endtask

   task automatic t_saturate();
      do_reset();
      cfg_en = 1'b1;
      hold(1, 130);
      chk_byte("R5 sat pulse", 0, 8'h7F);
      chk("R8 no ovf pend", {31'd0, rx_pend}, 0);
      hold(0, 2);
      chk_byte("R5 remainder", 1, 8'h03);
      do_reset();
      cfg_irq_en = 1'b1;
      cfg_ovf_irq_en = 1'b1;
      cfg_en = 1'b1;
      hold(0, 128);
      chk_byte("R5 sat space", 0, 8'hFF);
      chk("R8 ovf pend", {31'd0, rx_pend}, 1);
      chk("R10 ovf irq", {31'd0, irq}, 1);
   endtask

   task automatic t_default();
      do_reset();
      cfg_period = 8'd0;
      tclk = 50 * CPU;
      cfg_en = 1'b1;
      hold(1, 3); hold(0, 2);
      chk_byte("R3 default period", 0, 8'h03);
   endtask

   task automatic t_gate();
      do_reset();
      for (int k = 0; k < 20; k++) begin
         rx_in = ~rx_in;
         repeat (5) @(negedge clk);
      end
      chk("R11 idle pend", {31'd0, rx_pend}, 0);
      chk_byte("R11 idle byte", 0, 8'h00);
      cfg_en = 1'b1;
      hold(0, 2); hold(1, 3); hold(0, 2);
      chk_byte("R11 first run", 0, 8'h82);
      chk_byte("R11 second run", 1, 8'h03);
      cfg_en = 1'b0;
      for (int k = 0; k < 10; k++) begin
         rx_in = ~rx_in;
         repeat (3) @(negedge clk);
      end
      cfg_en = 1'b1;
      hold(1, 3); hold(0, 2);
      chk_byte("R11 fresh after re-enable", 2, 8'h03);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_main();
      t_invert();
      t_saturate();
      t_default();
      t_gate();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule